// File: doc/BRIEF.md
# Thermal Monitor Status and Alert Controller

This block holds the register and control logic of a temperature monitor that sits on a two-wire management bus. It schedules conversions on an external converter, checks each finished sample against a high limit and a low limit, and latches alarm flags in a status byte. It drives an active-low alert line and answers an alert-response query with its own device address. The bus physical layer and the analog converter are outside the block. The bus side is a one-cycle command strobe with a command code and a data byte. The converter side is a start/abort/done handshake that returns a sample byte and an open-diode flag.

In run mode a programmable interval counter starts a new conversion after each idle gap. In standby no timed conversions happen, but a one-shot command still triggers exactly one. Alarm flags are sticky. A status read clears only the flags whose condition has gone. The alert line is raised when an alarm flag rises while interrupts are unmasked. It is released only by a granted alert-response query.

Top module: `thermAlertCtl`

## Requirements
- R1: After reset, status, configuration and the stored sample read 0x00, `alertN` is 1 and `araAck` is 0. Read and write command codes, decoded on a cycle where `regValid` is high: 0x00 read sample, 0x01 read status, 0x02 read config, 0x03 read high limit, 0x04 read low limit, 0x09 write config, 0x0A write interval, 0x0B write high limit, 0x0C write low limit, 0x0F one-shot. Read data appears on `regRdata` in the cycle after the command.
- R2: The status byte holds a converter-busy bit in bit 7, the high alarm in bit 4, the low alarm in bit 3 and the open-diode fault in bit 2. Bits 6, 5, 1 and 0 read 0. Bit 7 is 1 while a conversion is in progress.
- R3: A finished sample sets the high alarm when it is greater than the high limit and the low alarm when it is less than the low limit, compared unsigned. A sample flagged as open sets the open fault and leaves the stored sample unchanged. A good sample clears the open condition.
- R4: A status read returns the flags as they stand, then clears each flag whose condition is false for the stored sample and limits. A flag whose condition still holds stays set.
- R5: Config bit 7 is the alert mask and bit 6 is the stop bit. Bits 5 to 0 read 0. The limits read back as written.
- R6: Setting the stop bit during a conversion ends it at once. Busy reads 0 on the next command, `adcAbort` pulses once, and a late converter done is discarded.
- R7: In standby a one-shot command starts exactly one conversion.
- R8: A one-shot command received while a conversion is in progress is ignored.
- R9: In run mode with interval value r, `adcStart` goes high r+2 cycles after the cycle in which `adcDone` is high.
- R10: `alertN` falls when any alarm flag goes from 0 to 1 while the mask is 0. A rise while the mask is 1 leaves `alertN` high.
- R11: Setting the mask does not release an asserted alert.
- R12: An alert-response query while the alert is asserted and the mask is 0 yields `araAck` = 1 with `araAddr` = device address in the next cycle, and `alertN` returns to 1. With the mask set, or with no alert asserted, the query gets no answer.
- R13: After a release, samples that keep an already-set flag set do not reassert the alert. Only a flag rising again after a status read has cleared it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Command strobe |
| regWrite | input | 1 | 1 = write command, 0 = read command |
| regCmd | input | 8 | Command code |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, valid the cycle after a read |
| adcStart | output | 1 | One-cycle conversion start |
| adcAbort | output | 1 | One-cycle conversion abort |
| adcDone | input | 1 | One-cycle conversion complete |
| adcTemp | input | 8 | Converted sample |
| adcOpen | input | 1 | Sensor diode open during this conversion |
| alertN | output | 1 | Active-low alert |
| araQuery | input | 1 | Alert-response query strobe |
| araAck | output | 1 | Query answered |
| araAddr | output | 8 | Device address when answered, else 0 |

## Verification
The bench builds the block with a 4-bit interval register, an interval reset value of 3 and device address 0x98. The narrow interval keeps a full sweep of interval values 0 to 5 short, so every gap between conversions is measured against r+2. With the limits at 100 and 40, the bench steps samples across the whole byte range in steps of 3, with every seventh value flagged open. This drives each alarm flag through its rise, its persistence and its clearing, and checks the alert line against an arithmetic model of the sticky flags.

// File: rtl/thermAlertPkg.sv
package thermAlertPkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_RD_TEMP   = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_RD_STATUS = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_RD_CFG    = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_RD_HIGH   = 8'h03;
  localparam logic [BYTE_W-1:0] CMD_RD_LOW    = 8'h04;
  localparam logic [BYTE_W-1:0] CMD_WR_CFG    = 8'h09;
  localparam logic [BYTE_W-1:0] CMD_WR_RATE   = 8'h0A;
  localparam logic [BYTE_W-1:0] CMD_WR_HIGH   = 8'h0B;
  localparam logic [BYTE_W-1:0] CMD_WR_LOW    = 8'h0C;
  localparam logic [BYTE_W-1:0] CMD_ONESHOT   = 8'h0F;

  localparam int CFG_MASK_BIT = 7;
  localparam int CFG_STOP_BIT = 6;

  typedef enum logic {
    CONV_IDLE = 1'b0,
    CONV_RUN  = 1'b1
  } convState_t;

  typedef struct packed {
    logic wrCfg;
    logic wrHigh;
    logic wrLow;
    logic wrRate;
    logic rdStatus;
    logic rdCfg;
    logic rdTemp;
    logic rdHigh;
    logic rdLow;
    logic sampleLoad;
    logic araGrant;
  } strobes_t;

endpackage

// File: rtl/thermAlertCtrl.sv
module thermAlertCtrl
  import thermAlertPkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [BYTE_W-1:0] regCmd,
  input  logic [BYTE_W-1:0] regWdata,
  input  logic              adcDone,
  input  logic              runStop,
  input  logic [RATE_W-1:0] rateVal,
  input  logic              alertActive,
  input  logic              alertMask,
  input  logic              araQuery,
  output strobes_t          strobes,
  output logic              busy,
  output logic              adcStart,
  output logic              adcAbort
);

  convState_t  state;
  logic [RATE_W-1:0] intCnt;
  logic cmdWr, cmdRd;
  logic stopReq, abortNow, oneShotReq, autoFire, startNow;

  assign cmdWr = regValid & regWrite;
  assign cmdRd = regValid & ~regWrite;
  assign busy  = (state == CONV_RUN);

  assign stopReq    = cmdWr && (regCmd == CMD_WR_CFG) && regWdata[CFG_STOP_BIT];
  assign abortNow   = stopReq && busy;
  assign oneShotReq = cmdWr && (regCmd == CMD_ONESHOT);
  assign autoFire   = !busy && !runStop && !stopReq && (intCnt >= rateVal);
  assign startNow   = !busy && (oneShotReq || autoFire);

  always_comb begin
    strobes          = '0;
    strobes.wrCfg    = cmdWr && (regCmd == CMD_WR_CFG);
    strobes.wrHigh   = cmdWr && (regCmd == CMD_WR_HIGH);
    strobes.wrLow    = cmdWr && (regCmd == CMD_WR_LOW);
    strobes.wrRate   = cmdWr && (regCmd == CMD_WR_RATE);
    strobes.rdStatus = cmdRd && (regCmd == CMD_RD_STATUS);
    strobes.rdCfg    = cmdRd && (regCmd == CMD_RD_CFG);
    strobes.rdTemp   = cmdRd && (regCmd == CMD_RD_TEMP);
    strobes.rdHigh   = cmdRd && (regCmd == CMD_RD_HIGH);
    strobes.rdLow    = cmdRd && (regCmd == CMD_RD_LOW);
    strobes.sampleLoad = adcDone && busy && !abortNow;
    strobes.araGrant   = araQuery && alertActive && !alertMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= CONV_IDLE;
      intCnt   <= '0;
      adcStart <= 1'b0;
      adcAbort <= 1'b0;
    end else begin
      adcStart <= startNow;
      adcAbort <= abortNow;
      case (state)
        CONV_IDLE: if (startNow) state <= CONV_RUN;
        CONV_RUN:  if (abortNow || strobes.sampleLoad) state <= CONV_IDLE;
        default:   state <= CONV_IDLE;
      endcase
      if (busy || runStop || startNow) intCnt <= '0;
      else if (intCnt != '1)           intCnt <= intCnt + 1'b1;
    end
  end

  // R8: a one-shot during a conversion launches nothing
  a_r8_oneshot_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && oneShotReq) |=> !adcStart);

  // R6: stop during a conversion idles the converter at once
  a_r6_stop_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stopReq) |=> (!busy && adcAbort));

  // R7: every start pulse coincides with a conversion in progress
  a_r7_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> busy);

  // R9: no timed start while the stop bit holds
  a_r9_no_auto_standby: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && runStop && !oneShotReq) |=> !adcStart);

endmodule

// File: rtl/thermAlertDp.sv
module thermAlertDp
  import thermAlertPkg::*;
#(
  parameter int               RATE_W       = 8,
  parameter int               RATE_RESET   = 99,
  parameter logic [BYTE_W-1:0] LIM_HI_RESET = 8'd85,
  parameter logic [BYTE_W-1:0] LIM_LO_RESET = 8'd0,
  parameter logic [BYTE_W-1:0] DEV_ADDR     = 8'h98
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [BYTE_W-1:0] regWdata,
  input  logic [BYTE_W-1:0] adcTemp,
  input  logic              adcOpen,
  input  logic              busy,
  input  logic              araQuery,
  output logic [BYTE_W-1:0] regRdata,
  output logic              alertN,
  output logic              araAck,
  output logic [BYTE_W-1:0] araAddr,
  output logic              runStop,
  output logic              alertMask,
  output logic [RATE_W-1:0] rateVal,
  output logic              alertActive
);

  localparam logic [RATE_W-1:0] RATE_INIT = RATE_W'(RATE_RESET);

  logic [BYTE_W-1:0] limHi, limLo, tempReg, rdData;
  logic              openReg;
  logic [2:0]        flags, flagsNext, condNow, condSample;
  logic              riseAny;

  // flag order inside the 3-bit vectors: {high, low, open}
  assign condNow    = {tempReg > limHi, tempReg < limLo, openReg};
  assign condSample = adcOpen ? {tempReg > limHi, tempReg < limLo, 1'b1}
                              : {adcTemp > limHi, adcTemp < limLo, 1'b0};

  always_comb begin
    flagsNext = flags;
    if (strobes.rdStatus)   flagsNext = flagsNext & condNow;
    if (strobes.sampleLoad) flagsNext = flagsNext | condSample;
  end

  assign riseAny = |(flagsNext & ~flags);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alertMask   <= 1'b0;
      runStop     <= 1'b0;
      limHi       <= LIM_HI_RESET;
      limLo       <= LIM_LO_RESET;
      rateVal     <= RATE_INIT;
      tempReg     <= '0;
      openReg     <= 1'b0;
      flags       <= '0;
      alertActive <= 1'b0;
      araAck      <= 1'b0;
      rdData      <= '0;
    end else begin
      if (strobes.wrCfg) begin
        alertMask <= regWdata[CFG_MASK_BIT];
        runStop   <= regWdata[CFG_STOP_BIT];
      end
      if (strobes.wrHigh) limHi   <= regWdata;
      if (strobes.wrLow)  limLo   <= regWdata;
      if (strobes.wrRate) rateVal <= regWdata[RATE_W-1:0];
      if (strobes.sampleLoad) begin
        openReg <= adcOpen;
        if (!adcOpen) tempReg <= adcTemp;
      end
      flags <= flagsNext;
      if (riseAny && !alertMask) alertActive <= 1'b1;
      else if (strobes.araGrant) alertActive <= 1'b0;
      araAck <= strobes.araGrant;
      if (strobes.rdStatus)
        rdData <= {busy, 2'b00, flags, 2'b00};
      else if (strobes.rdCfg)
        rdData <= {alertMask, runStop, 6'b0};
      else if (strobes.rdTemp)
        rdData <= tempReg;
      else if (strobes.rdHigh)
        rdData <= limHi;
      else if (strobes.rdLow)
        rdData <= limLo;
    end
  end

  assign regRdata = rdData;
  assign alertN   = ~alertActive;
  assign araAddr  = araAck ? DEV_ADDR : '0;

  // R4: a status read drops a high flag whose condition has gone
  a_r4_read_drops_gone: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStatus && !strobes.sampleLoad && !condNow[2]) |=> !flags[2]);

  // R4: a status read keeps a low flag whose condition persists
  a_r4_read_keeps_live: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStatus && flags[1] && condNow[1]) |=> flags[1]);

  // R11: only a granted query releases the alert
  a_r11_mask_keeps_alert: assert property (@(posedge clk) disable iff (!rstN)
    (alertActive && !strobes.araGrant) |=> alertActive);

  // R12: a masked query is never answered
  a_r12_no_answer_masked: assert property (@(posedge clk) disable iff (!rstN)
    (araQuery && alertMask) |=> !araAck);

  // R12: an answer comes with the alert released
  a_r12_ack_releases: assert property (@(posedge clk) disable iff (!rstN)
    araAck |-> (alertN && araAddr == DEV_ADDR));

  // R10: with the mask set an idle alert stays idle
  a_r10_masked_no_raise: assert property (@(posedge clk) disable iff (!rstN)
    (!alertActive && alertMask) |=> !alertActive);

endmodule

// File: rtl/thermAlertCtl.sv
module thermAlertCtl
  import thermAlertPkg::*;
#(
  parameter int               RATE_W       = 8,
  parameter int               RATE_RESET   = 99,
  parameter logic [BYTE_W-1:0] LIM_HI_RESET = 8'd85,
  parameter logic [BYTE_W-1:0] LIM_LO_RESET = 8'd0,
  parameter logic [BYTE_W-1:0] DEV_ADDR     = 8'h98
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [BYTE_W-1:0] regCmd,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  output logic              adcStart,
  output logic              adcAbort,
  input  logic              adcDone,
  input  logic [BYTE_W-1:0] adcTemp,
  input  logic              adcOpen,
  output logic              alertN,
  input  logic              araQuery,
  output logic              araAck,
  output logic [BYTE_W-1:0] araAddr
);

  strobes_t          strobes;
  logic              busy, runStop, alertMask, alertActive;
  logic [RATE_W-1:0] rateVal;

  thermAlertCtrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regValid(regValid), .regWrite(regWrite), .regCmd(regCmd), .regWdata(regWdata),
    .adcDone(adcDone), .runStop(runStop), .rateVal(rateVal),
    .alertActive(alertActive), .alertMask(alertMask), .araQuery(araQuery),
    .strobes(strobes), .busy(busy), .adcStart(adcStart), .adcAbort(adcAbort)
  );

  thermAlertDp #(
    .RATE_W(RATE_W), .RATE_RESET(RATE_RESET),
    .LIM_HI_RESET(LIM_HI_RESET), .LIM_LO_RESET(LIM_LO_RESET), .DEV_ADDR(DEV_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWdata(regWdata),
    .adcTemp(adcTemp), .adcOpen(adcOpen), .busy(busy), .araQuery(araQuery),
    .regRdata(regRdata), .alertN(alertN), .araAck(araAck), .araAddr(araAddr),
    .runStop(runStop), .alertMask(alertMask), .rateVal(rateVal),
    .alertActive(alertActive)
  );

endmodule

// File: tb/thermAlertCtl_bench.sv
module thermAlertCtl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RATE_W     = 4;
  localparam int LAT        = 3;
  localparam logic [7:0] DEV = 8'h98;
  localparam int HI = 100;
  localparam int LO = 40;

  logic clk, rstN, regValid, regWrite, adcDone, adcOpen, araQuery;
  logic [7:0] regCmd, regWdata, adcTemp;
  logic [7:0] regRdata, araAddr;
  logic adcStart, adcAbort, alertN, araAck;

  int nChecks = 0, nFail = 0;
  int negCount = 0, pendCnt = 0, startCount = 0, doneCount = 0, abortCount = 0;
  int lastDoneNeg = 0, lastGap = 0;

  int mTemp, limH, limL;
  bit mOpen, mMask, mAlert;
  bit [2:0] mFlags;

  thermAlertCtl #(.RATE_W(RATE_W), .RATE_RESET(3), .DEV_ADDR(DEV)) u_thermAlertCtl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regCmd(regCmd), .regWdata(regWdata), .regRdata(regRdata),
    .adcStart(adcStart), .adcAbort(adcAbort), .adcDone(adcDone),
    .adcTemp(adcTemp), .adcOpen(adcOpen), .alertN(alertN),
    .araQuery(araQuery), .araAck(araAck), .araAddr(araAddr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // converter model: done LAT negedges after a start; ignores abort on purpose
  always @(negedge clk) begin
    negCount++;
    adcDone = 1'b0;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        adcDone = 1'b1;
        doneCount++;
        lastDoneNeg = negCount;
      end
    end
    if (adcStart) begin
      startCount++;
      lastGap = negCount - lastDoneNeg;
      pendCnt = LAT;
    end
    if (adcAbort) abortCount++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] cmd, input logic [7:0] d);
    regCmd = cmd; regWdata = d; regWrite = 1'b1; regValid = 1'b1;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] cmd, output logic [7:0] d);
    regCmd = cmd; regWrite = 1'b0; regValid = 1'b1;
    @(negedge clk);
    regValid = 1'b0;
    d = regRdata;
  endtask

  function automatic bit [2:0] condOf();
    return {mTemp > limH, mTemp < limL, mOpen};
  endfunction

  task automatic readStatus(input string req, input bit expBusy);
    logic [7:0] d;
    rdReg(8'h01, d);
    chk(req, d, {expBusy, 2'b00, mFlags, 2'b00});
    mFlags = mFlags & condOf();
  endtask

  task automatic doSample(input int t, input bit open);
    bit [2:0] nf;
    adcTemp = t[7:0]; adcOpen = open;
    wrReg(8'h0F, 8'h00);
    repeat (LAT + 3) @(negedge clk);
    if (open) mOpen = 1'b1;
    else begin mOpen = 1'b0; mTemp = t; end
    nf = mFlags | condOf();
    if (((nf & ~mFlags) != 0) && !mMask) mAlert = 1'b1;
    mFlags = nf;
  endtask

  task automatic doAra(input string req);
    araQuery = 1'b1;
    @(negedge clk);
    araQuery = 1'b0;
    if (mAlert && !mMask) begin
      chk(req, {araAck, araAddr}, {1'b1, DEV});
      mAlert = 1'b0;
    end else begin
      chk(req, {araAck, araAddr}, 9'h000);
    end
    chk(req, alertN, !mAlert);
  endtask

  initial begin
    automatic logic [7:0] d;
    automatic int s0, a0, d0;
    rstN = 1'b0; regValid = 1'b0; regWrite = 1'b0; regCmd = '0; regWdata = '0;
    adcDone = 1'b0; adcTemp = 8'd50; adcOpen = 1'b0; araQuery = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(8'h01, d); chk("R1 status", d, 8'h00);
    rdReg(8'h02, d); chk("R1 config", d, 8'h00);
    rdReg(8'h00, d); chk("R1 sample", d, 8'h00);
    chk("R1 alertN", alertN, 1);
    chk("R1 araAck", araAck, 0);

    // standby, program limits, R5 readback
    wrReg(8'h09, 8'h40);
    repeat (10) @(negedge clk);
    wrReg(8'h0B, HI[7:0]); wrReg(8'h0C, LO[7:0]);
    limH = HI; limL = LO;
    rdReg(8'h03, d); chk("R5 high limit", d, HI);
    rdReg(8'h04, d); chk("R5 low limit", d, LO);
    wrReg(8'h09, 8'hFF);
    rdReg(8'h02, d); chk("R5 config reserved", d, 8'hC0);
    wrReg(8'h09, 8'h40);
    rdReg(8'h02, d); chk("R5 config standby", d, 8'h40);

    mMask = 0; mAlert = 0; mFlags = '0; mOpen = 0; mTemp = 50;
    doSample(50, 0);
    readStatus("R4 flush", 0);
    readStatus("R4 flush", 0);

    // R7/R8/R2: one-shot in standby, busy bit, second one-shot ignored
    s0 = startCount;
    adcTemp = 8'd60; adcOpen = 1'b0;
    wrReg(8'h0F, 8'h00);
    readStatus("R2 busy bit", 1);
    wrReg(8'h0F, 8'h00);
    repeat (LAT + 6) @(negedge clk);
    mTemp = 60;
    chk("R8 one-shot while busy", startCount - s0, 1);
    repeat (20) @(negedge clk);
    chk("R7 single conversion in standby", startCount - s0, 1);

    // R6: stop during conversion
    s0 = startCount; a0 = abortCount;
    adcTemp = 8'd200;
    wrReg(8'h0F, 8'h00);
    wrReg(8'h09, 8'h40);
    readStatus("R6 busy after stop", 0);
    chk("R6 abort pulse", abortCount - a0, 1);
    repeat (10) @(negedge clk);
    rdReg(8'h00, d); chk("R6 late done discarded", d, mTemp);
    readStatus("R6 flags untouched", 0);

    // R3/R4/R10 sweep over the sample range
    for (int t = 0; t < 256; t += 3) begin
      doSample(t, (t % 7) == 0);
      rdReg(8'h00, d); chk("R3 stored sample", d, mTemp);
      readStatus("R4 status read", 0);
      if ((t % 2) == 0) readStatus("R4 second read", 0);
      chk("R10 alert follows rise", alertN, !mAlert);
    end

    // R9: interval sweep in run mode
    adcTemp = 8'd50; adcOpen = 1'b0;
    for (int r = 0; r < 6; r++) begin
      wrReg(8'h0A, r[7:0]);
      wrReg(8'h09, 8'h80);
      d0 = doneCount;
      while (doneCount < d0 + 2) @(negedge clk);
      s0 = startCount;
      while (startCount == s0) @(negedge clk);
      chk("R9 interval gap", lastGap, r + 2);
      wrReg(8'h09, 8'hC0);
      repeat (10) @(negedge clk);
    end
    mTemp = 50; mOpen = 0;
    mFlags = mFlags | condOf();
    wrReg(8'h09, 8'h40);
    mMask = 0;
    readStatus("R4 after run", 0);
    readStatus("R4 after run", 0);

    // R10-R13 alert and response
    doAra("R12 release leftover");
    doAra("R12 no alert no answer");
    doSample(120, 0);
    chk("R10 alert on rise", alertN, 0);
    wrReg(8'h09, 8'hC0); mMask = 1;
    chk("R11 mask keeps alert", alertN, 0);
    doAra("R12 masked query");
    wrReg(8'h09, 8'h40); mMask = 0;
    doAra("R12 answered query");
    doSample(120, 0);
    chk("R13 held flag no reassert", alertN, 1);
    readStatus("R4 persists", 0);
    doSample(120, 0);
    chk("R13 still released", alertN, 1);
    doSample(50, 0);
    readStatus("R4 cleared", 0);
    doSample(120, 0);
    chk("R13 reassert after clear", alertN, 0);
    doAra("R12 answered again");
    doSample(50, 0);
    readStatus("R4 cleared", 0);
    wrReg(8'h09, 8'hC0); mMask = 1;
    doSample(120, 0);
    chk("R10 masked rise", alertN, 1);
    doAra("R12 masked no alert");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule